// File: doc/BRIEF.md
# Cascaded Bit-Slice Ripple ALU

A combinational arithmetic and logic unit of parameterised width, assembled from one repeated single-bit cell. Each cell holds an AND, an OR, an inverter on the B operand, and a full adder whose carry is passed to the cell above. Carry into the least significant cell comes from the increment input, and the carry leaving the top cell is brought out.

Each operand has its own gate. A separate control inverts the A operand after its gate. Setting these gates together with the two-bit function code and the increment bit produces every one-operand result a datapath needs, such as pass B, complement, increment, decrement and the constants 0, 1 and -1. The same controls also produce the two-operand sums, the difference B-A and the bitwise AND and OR. A negative flag and a zero flag accompany the result. Any shifter that follows the ALU is outside this block.

Top module: `slice_alu`

## Requirements
- R1: The function code selects the result per bit: 2'b00 AND, 2'b01 OR, 2'b10 inverse of the gated B operand, 2'b11 sum.
- R2: The effective A operand of each bit is (A bit AND a_en) XOR a_inv, and the effective B operand is B bit AND b_en.
- R3: With code 2'b11, {cout, result} equals effective A plus effective B plus cin_inc, where cin_inc is the carry into bit 0 and the carry ripples through every bit.
- R4: One-operand functions with a_en=0 give B (b_en=1, a_inv=0, cin_inc=0, sum), NOT B (code 2'b10, b_en=1), and B+1 (as B with cin_inc=1).
- R5: One-operand functions with a_en=0 give B-1 (b_en=1, a_inv=1, cin_inc=0, sum), 0 (b_en=0, a_inv=0, cin_inc=0), 1 (as 0 with cin_inc=1) and -1 (b_en=0, a_inv=1, cin_inc=0).
- R6: Two-operand functions with a_en=b_en=1 give A+B (cin_inc=0), A+B+1 (cin_inc=1), B-A (a_inv=1, cin_inc=1), A AND B and A OR B.
- R7: neg equals the most significant result bit.
- R8: zero is 1 exactly when every result bit is 0.
- R9: cin_inc has no effect on result for the codes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| func | input | 2 | Function code |
| a_en | input | 1 | Gate for operand A |
| b_en | input | 1 | Gate for operand B |
| a_inv | input | 1 | Invert gated A |
| cin_inc | input | 1 | Carry into bit 0 |
| result | output | WIDTH | Result |
| cout | output | 1 | Carry out of top bit |
| neg | output | 1 | Result sign |
| zero | output | 1 | Result is zero |

## Verification
The hardest case to reach is a carry that travels the whole chain from bit 0 to cout. Random operands rarely produce one. A rare case is B-1 with B=0, which borrows through every bit. Another is A+B+1 where A and B are complements, so that the carry-in propagates to the top. The stimulus aims at these cases with all-ones, zero and complementary operand pairs. It then adds random vectors under every control setting and compares each against an arithmetic model in the bench.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       func,
  input  logic             a_en,
  input  logic             b_en,
  input  logic             a_inv,
  input  logic             cin_inc,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             neg,
  output logic             zero
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin_inc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic ae, be, half;
    assign ae   = (a[i] & a_en) ^ a_inv;
    assign be   = b[i] & b_en;
    assign half = ae ^ be;
    assign carry[i+1] = (ae & be) | (carry[i] & half);
    always_comb begin
      case (func)
        2'b00:   result[i] = ae & be;
        2'b01:   result[i] = ae | be;
        2'b10:   result[i] = ~be;
        default: result[i] = half ^ carry[i];
      endcase
    end
  end

  assign cout = carry[WIDTH];
  assign neg  = result[WIDTH-1];
  assign zero = ~|result;
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [1:0]       func,
  input logic             a_en,
  input logic             b_en,
  input logic             a_inv,
  input logic             cin_inc,
  input logic [WIDTH-1:0] result,
  input logic             cout,
  input logic             neg,
  input logic             zero
);
  logic [WIDTH-1:0] ea, eb;
  logic [WIDTH:0]   total;

  always_comb begin
    ea    = a_en ? (a_inv ? ~a : a) : (a_inv ? '1 : '0);
    eb    = b_en ? b : '0;
    total = {1'b0, ea} + {1'b0, eb} + {{WIDTH{1'b0}}, cin_inc};
    // R3
    sum_ripple_chk: assert (func != 2'b11 || {cout, result} == total);
    // R1
    and_fn_chk: assert (func != 2'b00 || result == (ea & eb));
    // R1
    or_fn_chk: assert (func != 2'b01 || result == (ea | eb));
    // R1
    notb_fn_chk: assert (func != 2'b10 || result == ~eb);
    // R7 R8
    flag_excl_chk: assert (!(zero && neg));
    // R8
    zero_flag_chk: assert (zero == (result == '0));
  end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    logic         chk_co;
    string        tag;
  } exp_t;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, result;
  logic [1:0]   func;
  logic a_en, b_en, a_inv, cin_inc, cout, neg, zero;

  slice_alu #(.WIDTH(W)) u_dut (.*);

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic [1:0] f, input logic ea_, input logic eb_,
                       input logic ia_, input logic ic,
                       input logic [W-1:0] er, input logic eco, input logic cc,
                       input string t);
    exp_t e;
    @(posedge clk);
    #1;
    a = ia; b = ib; func = f; a_en = ea_; b_en = eb_; a_inv = ia_; cin_inc = ic;
    e.res = er; e.co = eco; e.chk_co = cc; e.tag = t;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (result !== e.res || (e.chk_co && cout !== e.co)) begin
        n_bad++;
        $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b",
                 e.tag, result, cout, e.res, e.co);
      end
      n_vec++;
      if (neg !== e.res[W-1]) begin
        n_bad++;
        $display("FAIL R7 %s: neg=%b expected %b", e.tag, neg, e.res[W-1]);
      end
      n_vec++;
      if (zero !== (e.res == '0)) begin
        n_bad++;
        $display("FAIL R8 %s: zero=%b expected %b", e.tag, zero, e.res == '0);
      end
    end
  end

  initial begin
    logic [W:0] s;
    a = '0; b = '0; func = 2'b00; a_en = 0; b_en = 0; a_inv = 0; cin_inc = 0;
    // initial idle state, AND of zeros
    apply('0, '0, 2'b00, 0, 0, 0, 0, '0, 0, 0, "R1 idle");
    // R4 one-operand
    apply(8'h5A, 8'h3C, 2'b11, 0, 1, 0, 0, 8'h3C, 0, 1, "R4 pass B");
    apply(8'h5A, 8'h3C, 2'b10, 0, 1, 0, 0, 8'hC3, 0, 0, "R4 not B");
    apply(8'h5A, 8'hFF, 2'b11, 0, 1, 0, 1, 8'h00, 1, 1, "R4 B+1 wrap");
    // R5 one-operand
    apply(8'h11, 8'h00, 2'b11, 0, 1, 1, 0, 8'hFF, 0, 1, "R5 B-1 borrow");
    apply(8'h11, 8'h80, 2'b11, 0, 1, 1, 0, 8'h7F, 1, 1, "R5 B-1");
    apply(8'hAA, 8'h55, 2'b11, 0, 0, 0, 0, 8'h00, 0, 1, "R5 zero");
    apply(8'hAA, 8'h55, 2'b11, 0, 0, 0, 1, 8'h01, 0, 1, "R5 one");
    apply(8'hAA, 8'h55, 2'b11, 0, 0, 1, 0, ONES, 0, 1, "R5 minus one");
    // R6 two-operand
    apply(8'h0F, 8'hF0, 2'b11, 1, 1, 0, 1, 8'h00, 1, 1, "R6 A+B+1 full ripple");
    apply(8'h70, 8'h20, 2'b11, 1, 1, 0, 0, 8'h90, 0, 1, "R6 A+B");
    apply(8'h05, 8'h03, 2'b11, 1, 1, 1, 1, 8'hFE, 0, 1, "R6 B-A negative");
    apply(8'h03, 8'h05, 2'b11, 1, 1, 1, 1, 8'h02, 1, 1, "R6 B-A");
    apply(8'hCC, 8'hAA, 2'b00, 1, 1, 0, 0, 8'h88, 0, 0, "R6 AND");
    apply(8'hCC, 8'hAA, 2'b01, 1, 1, 0, 0, 8'hEE, 0, 0, "R6 OR");
    // R2 gating and inversion on logic paths
    apply(8'hCC, 8'hAA, 2'b01, 0, 1, 1, 0, ONES, 0, 0, "R2 inverted disabled A");
    apply(8'hCC, 8'hAA, 2'b01, 1, 0, 1, 0, 8'h33, 0, 0, "R2 inverted A, B off");
    apply(8'hCC, 8'hAA, 2'b10, 1, 0, 0, 0, ONES, 0, 0, "R2 B gated off");
    // R9 increment ignored by logic codes
    apply(8'hCC, 8'hAA, 2'b00, 1, 1, 0, 1, 8'h88, 0, 0, "R9 AND inc");
    apply(8'hCC, 8'hAA, 2'b01, 1, 1, 0, 1, 8'hEE, 0, 0, "R9 OR inc");
    apply(8'hCC, 8'h00, 2'b10, 1, 1, 0, 1, ONES, 0, 0, "R9 NOT inc");
    // R3 random sums with every gating, against arithmetic model
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra, rb, xa, xb;
      logic [3:0] c;
      ra = W'($urandom); rb = W'($urandom); c = 4'($urandom);
      xa = c[0] ? (c[2] ? ~ra : ra) : (c[2] ? ONES : '0);
      xb = c[1] ? rb : '0;
      s = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, c[3]};
      apply(ra, rb, 2'b11, c[0], c[1], c[2], c[3], s[W-1:0], s[W], 1, "R3 random sum");
    end
    // R1 random logic functions
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] ra, rb, er;
      logic [1:0] f;
      ra = W'($urandom); rb = W'($urandom); f = 2'($urandom_range(2));
      er = (f == 2'b00) ? (ra & rb) : (f == 2'b01) ? (ra | rb) : ~rb;
      apply(ra, rb, f, 1, 1, 0, 0, er, 0, 0, "R1 random logic");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule